// File: doc/BRIEF.md
# Dual-Mode FIFO with Shared Read Flag

This block is a first-in first-out buffer that connects a writer and a reader running on separate clocks. Words enter on the write clock whenever the write enable is high and the buffer has room. They leave on the read clock. The pointers cross between the two domains as gray codes, each through two flip-flops.

A select input is latched while reset is low. It puts the read side into one of two modes for the whole of the run that follows.

- **Standard mode:** the single read flag output is an active-low empty indication. A word is returned only when a read is requested.
- **Look-ahead mode:** the same flag is an active-low output-ready indication. The head word is placed on the data outputs before any read is made. After the last word has been taken, that word stays on the outputs.

In look-ahead mode the output register counts as one more storage place. The buffer therefore holds one word more than the memory array.

Top module: `dmode_fifo`

## Requirements
- R1: While reset is low and after it is released, with no writes made, the read data is 0. The flag is low (empty) in standard mode (select = 0) and high (not ready) in look-ahead mode (select = 1).
- R2: In standard mode the flag is high exactly when the read side sees at least one unread word. A write accepted at write edge k makes the flag high after read edge k+2, with both clocks aligned. The flag goes low right after the read edge that takes the last visible word.
- R3: In standard mode, a read clock edge with read enable low and the flag high loads the oldest word onto the read data. If read enable is high, or the flag is low, at that edge, the read data does not change.
- R4: In look-ahead mode, a word written at edge k into an empty FIFO appears on the read data, and the flag goes low, after read edge k+3, with no read requested.
- R5: In look-ahead mode, a read edge with read enable low and the flag low takes the presented word. If a further word is visible, it is presented at that same edge and the flag stays low. The flag never rises at an edge where read enable is high.
- R6: In look-ahead mode, after the final word is taken the flag goes high and the read data keeps showing that word. Reads made while the flag is high are ignored.
- R7: The select input is sampled only while reset is low. Changing it afterwards has no effect on the mode.
- R8: Words come out in the order they were written. A write is dropped when the accepted writes, minus the reads the writer has seen through its two-stage return path, equal the array depth. Total capacity is 16 words in standard mode and 17 in look-ahead mode at the default depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Synchronous active-low master reset for both clock domains; also latches the mode select |
| look_ahead_sel | input | 1 | Mode select sampled during reset: 0 standard, 1 look-ahead |
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Active-high write request |
| wr_data | input | DW | Word to store |
| rclk | input | 1 | Read clock |
| rd_en_n | input | 1 | Active-low read request |
| rd_data | output | DW | Read data register |
| rd_flag | output | 1 | Active-low empty flag in standard mode, active-low output-ready flag in look-ahead mode |

## Verification
The assertions check four things on every cycle:
- In standard mode the read data changes only at an accepted read.
- In look-ahead mode, while the flag is high, the held word stays put and readiness is never withdrawn without a read.
- The latched mode never changes outside reset.
- The writer's fill level never exceeds the depth, and the gray write pointer moves by at most one bit per edge.

The exact two- and three-edge flag latencies, the extra location in look-ahead mode, the dropped writes when full, and the word order can only be shown by the bench's scenarios and by its cycle-by-cycle reference model.

// File: rtl/dmode_fifo_pkg.sv
// Package: shared types for the dual-mode FIFO.
// Assumes nothing; holds only the read-mode encoding.
package dmode_fifo_pkg;
    typedef enum logic {
        RDM_STANDARD  = 1'b0,
        RDM_LOOKAHEAD = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/fifo_ptr_sync.sv
// Module: fifo_ptr_sync
// Carries a gray-coded pointer into another clock domain through two
// flip-flops and presents it as binary. Assumes the source changes the
// gray value by at most one bit per source clock.
module fifo_ptr_sync #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] stage1_q;
    logic [PW-1:0] stage2_q;

    // Two-stage resynchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_in;
            stage2_q <= stage1_q;
        end
    end

    // Gray to binary conversion, top bit downwards.
    always_comb begin
        bin_out[PW-1] = stage2_q[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage2_q[i];
        end
    end
endmodule

// File: rtl/fifo_dp_ram.sv
// Module: fifo_dp_ram
// Storage array with one write port on the write clock and one
// asynchronous read port. Assumes the read address only points at
// locations already written.
module fifo_dp_ram #(
    parameter int DW = 8,
    parameter int AW = 4,
    localparam int DEPTH = 1 << AW
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read of the head location.
    assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_port.sv
// Module: fifo_wr_port
// Write pointer, full detection and gray pointer export. Assumes the
// read pointer arrives already synchronized and converted to binary.
module fifo_wr_port #(
    parameter int AW = 4,
    localparam int PW = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] rsync_bin,
    output logic          wr_fire,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic [PW-1:0] wr_level
);
    localparam logic [PW-1:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    logic [PW-1:0] wbin_q;
    logic [PW-1:0] wbin_nx;
    logic          full;

    // Fill level as seen from the write side and the resulting full state.
    always_comb begin
        wr_level = wbin_q - rsync_bin;
        full     = (wr_level == DEPTH_V);
        wr_fire  = wr_en && !full;
        wbin_nx  = wbin_q + PW'(wr_fire);
    end

    // Binary and gray write pointers.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin_q <= '0;
            wgray  <= '0;
        end else begin
            wbin_q <= wbin_nx;
            wgray  <= (wbin_nx >> 1) ^ wbin_nx;
        end
    end

    assign waddr = wbin_q[AW-1:0];
endmodule

// File: rtl/fifo_rd_port.sv
// Module: fifo_rd_port
// Read pointer, mode latch, output register and shared flag. In standard
// mode the output register loads only on a read; in look-ahead mode it
// is a presentation stage that refills itself. Assumes the write pointer
// arrives synchronized and converted to binary.
module fifo_rd_port
    import dmode_fifo_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4,
    localparam int PW = AW + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          look_ahead_sel,
    input  logic          rd_en_n,
    input  logic [PW-1:0] wsync_bin,
    input  logic [DW-1:0] ram_q,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag,
    output logic          look_q
);
    rd_mode_e      mode_q;
    logic [PW-1:0] rbin_q;
    logic [PW-1:0] rbin_nx;
    logic          hold_vld_q;
    logic          avail;
    logic          pull;

    // Mode latch: follows the select only while reset is held.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            mode_q <= rd_mode_e'(look_ahead_sel);
        end
    end

    // Decide whether the head word leaves the array this edge.
    always_comb begin
        avail = (wsync_bin != rbin_q);
        if (mode_q == RDM_LOOKAHEAD) begin
            pull = avail && (!hold_vld_q || !rd_en_n);
        end else begin
            pull = avail && !rd_en_n;
        end
        rbin_nx = rbin_q + PW'(pull);
    end

    // Read pointers in binary and gray.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin_q <= '0;
            rgray  <= '0;
        end else begin
            rbin_q <= rbin_nx;
            rgray  <= (rbin_nx >> 1) ^ rbin_nx;
        end
    end

    // Output register: loads the head word whenever it is pulled.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (pull) begin
            rd_data <= ram_q;
        end
    end

    // Presentation-stage valid bit for look-ahead mode.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            hold_vld_q <= 1'b0;
        end else if (mode_q == RDM_LOOKAHEAD) begin
            if (pull) begin
                hold_vld_q <= 1'b1;
            end else if (!rd_en_n) begin
                hold_vld_q <= 1'b0;
            end
        end
    end

    assign rd_flag = (mode_q == RDM_LOOKAHEAD) ? !hold_vld_q : avail;
    assign raddr   = rbin_q[AW-1:0];
    assign look_q  = (mode_q == RDM_LOOKAHEAD);
endmodule

// File: rtl/dmode_fifo.sv
// Module: dmode_fifo (top)
// Dual-clock FIFO whose read side runs either as a standard FIFO with an
// active-low empty flag or as a look-ahead FIFO with an active-low
// output-ready flag. Assumes rst_n is held low for at least one edge of
// each clock.
module dmode_fifo #(
    parameter int DW = 8,
    parameter int AW = 4,
    localparam int PW = AW + 1
) (
    input  logic          rst_n,
    input  logic          look_ahead_sel,
    input  logic          wclk,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rclk,
    input  logic          rd_en_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag
);
    logic          wr_fire;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wsync_bin;
    logic [PW-1:0] rsync_bin;
    logic [PW-1:0] wr_level;
    logic [DW-1:0] ram_q;
    logic          look_q;

    fifo_wr_port #(.AW(AW)) wr_port_i (
        .wclk      (wclk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rsync_bin (rsync_bin),
        .wr_fire   (wr_fire),
        .waddr     (waddr),
        .wgray     (wgray),
        .wr_level  (wr_level)
    );

    fifo_dp_ram #(.DW(DW), .AW(AW)) ram_i (
        .wclk  (wclk),
        .we    (wr_fire),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (ram_q)
    );

    fifo_ptr_sync #(.PW(PW)) w2r_sync_i (
        .clk     (rclk),
        .rst_n   (rst_n),
        .gray_in (wgray),
        .bin_out (wsync_bin)
    );

    fifo_ptr_sync #(.PW(PW)) r2w_sync_i (
        .clk     (wclk),
        .rst_n   (rst_n),
        .gray_in (rgray),
        .bin_out (rsync_bin)
    );

    fifo_rd_port #(.DW(DW), .AW(AW)) rd_port_i (
        .rclk           (rclk),
        .rst_n          (rst_n),
        .look_ahead_sel (look_ahead_sel),
        .rd_en_n        (rd_en_n),
        .wsync_bin      (wsync_bin),
        .ram_q          (ram_q),
        .raddr          (raddr),
        .rgray          (rgray),
        .rd_data        (rd_data),
        .rd_flag        (rd_flag),
        .look_q         (look_q)
    );
endmodule

// File: rtl/dmode_fifo_chk.sv
// Module: dmode_fifo_chk
// Assertion checker bound into dmode_fifo. Observes ports plus the
// latched mode, the write-side fill level and the gray write pointer.
module dmode_fifo_chk #(
    parameter int DW = 8,
    parameter int AW = 4,
    localparam int PW = AW + 1
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          look_q,
    input logic          rd_en_n,
    input logic          rd_flag,
    input logic [DW-1:0] rd_data,
    input logic [PW-1:0] wr_level,
    input logic [PW-1:0] wgray
);
    localparam logic [PW-1:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    // R3: standard-mode data changes only on an accepted read.
    p_std_hold_r3: assert property (@(posedge rclk) disable iff (!rst_n)
        (!look_q && (rd_en_n || !rd_flag)) |=> $stable(rd_data));

    // R6: while not ready, look-ahead data holds the last word.
    p_look_hold_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        (look_q && rd_flag) |=> (!rd_flag || $stable(rd_data)));

    // R5: readiness is never withdrawn without a read.
    p_look_keep_r5: assert property (@(posedge rclk) disable iff (!rst_n)
        (look_q && !rd_flag && rd_en_n) |=> !rd_flag);

    // R7: the latched mode stays fixed outside reset.
    p_mode_fixed_r7: assert property (@(posedge rclk) disable iff (!rst_n)
        $stable(look_q));

    // R8: the writer never exceeds the array depth.
    p_no_overflow_r8: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_level <= DEPTH_V);

    // R8: the gray write pointer moves by at most one bit per edge.
    p_gray_step_r8: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

bind dmode_fifo dmode_fifo_chk #(.DW(DW), .AW(AW)) chk_i (
    .wclk     (wclk),
    .rclk     (rclk),
    .rst_n    (rst_n),
    .look_q   (look_q),
    .rd_en_n  (rd_en_n),
    .rd_flag  (rd_flag),
    .rd_data  (rd_data),
    .wr_level (wr_level),
    .wgray    (wgray)
);

// File: tb/dmode_fifo_tb_top.sv
// Bench for dmode_fifo: both clocks come from one 50 MHz source. A
// behavioural model (queue plus delayed counts) is compared on every cycle.
module dmode_fifo_tb_top;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          look_ahead_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic [DW-1:0] rd_data;
    logic          rd_flag;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit primed = 1'b0;

    always #10 clk = ~clk;

    dmode_fifo #(.DW(DW), .AW(AW)) dut_i (
        .rst_n          (rst_n),
        .look_ahead_sel (look_ahead_sel),
        .wclk           (clk),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .rclk           (clk),
        .rd_en_n        (rd_en_n),
        .rd_data        (rd_data),
        .rd_flag        (rd_flag)
    );

    // Reference model state.
    int          q[$];
    int          wr_cnt, wr_d1, wr_seen, rd_cnt, rd_d1, rd_seen;
    bit          m_look, m_vld;
    logic [DW-1:0] m_data;

    always @(posedge clk) begin : model
        int  avail;
        bit  full;
        bit  take;
        int  owc;
        int  orc;
        if (!rst_n) begin
            m_look = look_ahead_sel;
            q.delete();
            wr_cnt = 0; wr_d1 = 0; wr_seen = 0;
            rd_cnt = 0; rd_d1 = 0; rd_seen = 0;
            m_vld = 1'b0;
            m_data = '0;
            primed = 1'b1;
        end else begin
            avail = wr_seen - rd_cnt;
            full  = (wr_cnt - rd_seen) >= DEPTH;
            owc = wr_cnt;
            orc = rd_cnt;
            wr_seen = wr_d1; wr_d1 = owc;
            rd_seen = rd_d1; rd_d1 = orc;
            if (m_look) begin
                take = (avail > 0) && (!m_vld || !rd_en_n);
                if (take) begin
                    m_data = DW'(q.pop_front());
                    m_vld = 1'b1;
                    rd_cnt++;
                end else if (!rd_en_n) begin
                    m_vld = 1'b0;
                end
            end else if (!rd_en_n && avail > 0) begin
                m_data = DW'(q.pop_front());
                rd_cnt++;
            end
            if (wr_en && !full) begin
                q.push_back(int'(wr_data));
                wr_cnt++;
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (primed && !finished) begin
            total++;
            if (rd_data !== m_data) begin
                bad++;
                $display("FAIL R3 R5 R6 R8 rd_data act=%h exp=%h", rd_data, m_data);
            end
            total++;
            if (rd_flag !== (m_look ? !m_vld : (wr_seen != rd_cnt))) begin
                bad++;
                $display("FAIL R1 R2 R4 R7 rd_flag act=%b exp=%b", rd_flag,
                         m_look ? !m_vld : (wr_seen != rd_cnt));
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input bit sel);
        @(negedge clk);
        rst_n = 1'b0; look_ahead_sel = sel; wr_en = 1'b0; rd_en_n = 1'b1;
        cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic put(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic traffic(input int n, inout logic [15:0] lfsr);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_en = lfsr[0] | lfsr[3];
            wr_data = lfsr[11:4];
            rd_en_n = lfsr[1] & lfsr[5];
            look_ahead_sel = lfsr[7];
            @(negedge clk);
        end
        wr_en = 1'b0; rd_en_n = 1'b1;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int cnt;
        logic [15:0] lfsr;
        lfsr = 16'hACE1;

        // R1 standard reset state
        do_reset(1'b0);
        chk("R1 std flag", int'(rd_flag), 0);
        chk("R1 std data", int'(rd_data), 0);

        // R3 read while empty is ignored
        rd_en_n = 1'b0; cyc(2); rd_en_n = 1'b1;
        chk("R3 empty read ignored", int'(rd_data), 0);

        // R2 two-edge flag latency
        put(8'h11);
        chk("R2 flag after k", int'(rd_flag), 0);
        cyc(1);
        chk("R2 flag after k+1", int'(rd_flag), 0);
        cyc(1);
        chk("R2 flag after k+2", int'(rd_flag), 1);
        cyc(2);
        chk("R3 no read no data", int'(rd_data), 0);
        rd_en_n = 1'b0; cyc(1); rd_en_n = 1'b1;
        chk("R3 read data", int'(rd_data), 'h11);
        chk("R2 flag low after last", int'(rd_flag), 0);

        // R8 standard capacity: 20 writes, 16 kept
        for (int i = 0; i < 20; i++) put(DW'(8'h40 + i));
        cyc(6);
        cnt = 0;
        rd_en_n = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (rd_flag) cnt++;
            @(negedge clk);
        end
        rd_en_n = 1'b1;
        chk("R8 std capacity", cnt, DEPTH);
        chk("R8 std last word", int'(rd_data), 'h40 + DEPTH - 1);

        // R1 look-ahead reset state
        do_reset(1'b1);
        chk("R1 look flag", int'(rd_flag), 1);
        chk("R1 look data", int'(rd_data), 0);

        // R4 three-edge fall-through
        put(8'h5A);
        cyc(2);
        chk("R4 not yet ready", int'(rd_flag), 1);
        cyc(1);
        chk("R4 ready", int'(rd_flag), 0);
        chk("R4 head shown", int'(rd_data), 'h5A);

        // R5 stream of words, R6 hold of the last one
        put(8'h61); put(8'h62);
        cyc(4);
        rd_en_n = 1'b0; cyc(1);
        chk("R5 next word", int'(rd_data), 'h61);
        chk("R5 still ready", int'(rd_flag), 0);
        cyc(2); rd_en_n = 1'b1;
        chk("R6 not ready", int'(rd_flag), 1);
        chk("R6 last held", int'(rd_data), 'h62);
        rd_en_n = 1'b0; cyc(3); rd_en_n = 1'b1;
        chk("R6 reads ignored", int'(rd_data), 'h62);

        // R8 look-ahead capacity: 17
        for (int i = 0; i < 20; i++) put(DW'(8'h80 + i));
        cyc(6);
        cnt = 0;
        rd_en_n = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (!rd_flag) cnt++;
            @(negedge clk);
        end
        rd_en_n = 1'b1;
        chk("R8 look capacity", cnt, DEPTH + 1);

        // R7 select change after reset has no effect
        look_ahead_sel = 1'b0;
        put(8'h77);
        cyc(3);
        chk("R7 still look-ahead flag", int'(rd_flag), 0);
        chk("R7 still look-ahead data", int'(rd_data), 'h77);

        // Mixed traffic in both modes (model compares each cycle)
        traffic(600, lfsr);
        do_reset(1'b0);
        traffic(600, lfsr);

        cyc(2);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule